// File: doc/BRIEF.md
# Multiplexed-bus machine cycle sequencer

This block turns a single request from a processor core into the pin-level T-state sequence of one bus machine cycle on an 8-bit bus. The low address byte and the data byte share one set of pins. The core presents a cycle kind, a 16-bit address and, for writes, a data byte. It then pulses a request. The block supports five cycle kinds: opcode fetch, memory read, memory write, I/O read and I/O write.

Each cycle starts with an address state. In that state the high address byte goes out on its own pins and the low byte goes out on the shared pins, while a one-state latch strobe lets an external register hold the low byte. The following states move data on the shared pins under a read or write strobe. The memory/I-O select line and two status lines name the cycle kind for the whole cycle. An opcode fetch has one extra state, in which the core decodes the fetched byte. A read byte is captured internally. A one-clock done pulse marks the end of every cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, `ale_o`=0, `rd_no`=1, `wr_no`=1, `ad_oe_o`=0, `busy_o`=0, `done_o`=0, `io_m_o`=0 and `{s1_o,s0_o}`=00.
- R2: A request accepted while idle starts state T1 on the next clock. In T1, `ale_o`=1, `ad_oe_o`=1, `ad_o` carries address bits 7..0 and `a_hi_o` carries address bits 15..8. `ale_o` is 0 in every other state.
- R3: For the whole cycle (T1 to the last state), the kind code on `kind_i` sets `io_m_o` and `{s1_o,s0_o}` as follows: 0 opcode fetch gives 0/11; 1 memory read gives 0/10; 2 memory write gives 0/01; 3 I/O read gives 1/10; 4 I/O write gives 1/01.
- R4: In read kinds (0, 1 and 3), `rd_no` is 0 in T2 and T3 and 1 otherwise, and `ad_oe_o` is 0 from T2 onward. `wr_no` stays 1.
- R5: In write kinds (2 and 4), `wr_no` is 0 in T2 and T3, and `ad_oe_o`=1 with `ad_o` equal to the write data in T2 and T3. `rd_no` stays 1.
- R6: In read kinds, `rdata_o` takes the value on `ad_i` at the clock edge that ends T3. Values on `ad_i` in other states, and write cycles, leave `rdata_o` unchanged.
- R7: An opcode fetch adds a state T4 after T3. In T4, `rd_no`=1, `wr_no`=1 and `ad_oe_o`=0. A fetch therefore lasts four states, and every other kind lasts three.
- R8: `busy_o` is 1 in every T-state. `done_o` is a one-clock pulse in the clock that follows the last T-state, and `busy_o`=0 in that clock.
- R9: A request made while a cycle is running is ignored. A request with a kind code of 5, 6 or 7 is ignored: no T1 follows it.
- R10: `a_hi_o` holds address bits 15..8 in every T-state of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one T-state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, taken only while idle |
| kind_i | input | 3 | Cycle kind code (0..4) |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write data |
| ad_i | input | 8 | Shared pins as seen from outside |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | 8 | Last byte read |
| a_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Value driven on the shared pins |
| ad_oe_o | output | 1 | Shared pins driven when 1 |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |

## Verification
A vector table runs all five cycle kinds with different address and data bytes, and every pin is checked in every T-state. This separates the status and select encodings and the read and write strobe timing, and shows whether the fetch's extra state is present. While a read runs, the bench puts a decoy byte on `ad_i` in T2 and again after T3. Only the T3 value may be captured, so capture on the wrong edge shows up. Directed tests cover the reset state, a write following a read (the captured byte must stay), a request made during a cycle, and an unused kind code.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  function automatic logic kind_valid(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_is_read(kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_is_io(kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  // {s1,s0}
  function automatic logic [1:0] kind_status(kind_e k);
    case (k)
      K_FETCH:        return 2'b11;
      K_MRD, K_IORD:  return 2'b10;
      default:        return 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tstate_e           state_o,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o
);
  tstate_e state_q, state_d;
  kind_e   kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic done_q;
  logic start;

  assign start = (state_q == TS_IDLE) && req_i && kind_valid(kind_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      TS_IDLE: if (start) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3:   state_d = (kind_q == K_FETCH) ? TS_T4 : TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      kind_q  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q != TS_IDLE) && (state_d == TS_IDLE);
      if (start) begin
        kind_q  <= kind_e'(kind_i);
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign state_o = state_q;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign done_o  = done_q;

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r9_kind_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != TS_IDLE) && (state_d != TS_IDLE) |=> $stable(kind_q) && $stable(addr_q));
  a_r7_t4_fetch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T4) |-> (kind_q == K_FETCH));
endmodule

// File: rtl/bus_pin_decode.sv
module bus_pin_decode
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HI_W-1:0]   a_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  output logic [1:0]        status_o,
  output logic              busy_o
);
  logic active, mid, rd_kind;

  assign active  = (state_i != TS_IDLE);
  assign mid     = (state_i == TS_T2) || (state_i == TS_T3);
  assign rd_kind = kind_is_read(kind_i);

  always_comb begin
    a_hi_o   = '0;
    ad_o     = '0;
    ad_oe_o  = 1'b0;
    ale_o    = 1'b0;
    rd_no    = 1'b1;
    wr_no    = 1'b1;
    io_m_o   = 1'b0;
    status_o = 2'b00;
    if (active) begin
      a_hi_o   = addr_i[ADDR_W-1:DATA_W];
      io_m_o   = kind_is_io(kind_i);
      status_o = kind_status(kind_i);
    end
    if (state_i == TS_T1) begin
      ale_o   = 1'b1;
      ad_oe_o = 1'b1;
      ad_o    = addr_i[DATA_W-1:0];
    end else if (mid) begin
      if (rd_kind) begin
        rd_no = 1'b0;
      end else begin
        wr_no   = 1'b0;
        ad_oe_o = 1'b1;
        ad_o    = wdata_i;
      end
    end
  end

  assign busy_o = active;

  a_r4_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  a_r2_ale_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> rd_no && wr_no && ad_oe_o);
  a_r4_rd_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);
  a_r2_ale_one_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r10_hi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ale_o && $past(busy_o) |-> $stable(a_hi_o) && $stable(status_o));
endmodule

// File: rtl/bus_rdata_capture.sv
module bus_rdata_capture
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  kind_e             kind_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic cap;
  logic [DATA_W-1:0] rdata_q;

  // sample on the edge that closes T3
  assign cap = (state_i == TS_T3) && kind_is_read(kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (cap) rdata_q <= ad_i;
  end

  assign rdata_o = rdata_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != TS_T3) |=> $stable(rdata_q));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  output logic              s1_o,
  output logic              s0_o
);
  tstate_e state;
  kind_e   kind;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0] status;

  bus_tstate_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .req_i, .kind_i, .addr_i, .wdata_i,
    .state_o(state), .kind_o(kind), .addr_o(addr_q), .wdata_o(wdata_q),
    .done_o
  );

  bus_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i, .rst_ni, .state_i(state), .kind_i(kind), .addr_i(addr_q),
    .wdata_i(wdata_q), .a_hi_o, .ad_o, .ad_oe_o, .ale_o, .rd_no, .wr_no,
    .io_m_o, .status_o(status), .busy_o
  );

  bus_rdata_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .state_i(state), .kind_i(kind), .ad_i, .rdata_o
  );

  assign s1_o = status[1];
  assign s0_o = status[0];

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> rd_no && wr_no && !ad_oe_o && !ale_o && !io_m_o && !s1_o && !s0_o);
endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] kind = 3'd0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, ad_in = '0;
  logic busy, done, ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
  logic [7:0] rdata, a_hi, ad_out;
  int errors = 0, checks = 0;
  logic [7:0] exp_rd = 8'h00;

  always #4 clk = ~clk;

  bus_cycle_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .ad_i(ad_in), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .a_hi_o(a_hi), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .io_m_o(io_m), .s1_o(s1), .s0_o(s0)
  );

  // kind, addr, wdata, read value
  localparam logic [34:0] VEC [0:6] = '{
    {3'd0, 16'h2050, 8'h00, 8'h3C},
    {3'd1, 16'hBA55, 8'h00, 8'h65},
    {3'd2, 16'h4001, 8'h98, 8'h11},
    {3'd3, 16'h00F3, 8'h00, 8'hA7},
    {3'd4, 16'h0081, 8'h5A, 8'h22},
    {3'd0, 16'hFFFF, 8'h00, 8'hC3},
    {3'd2, 16'h0000, 8'hFF, 8'h00}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R1 idle pins"}, {ale, rd_n, wr_n, ad_oe, busy, io_m, s1, s0},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv,
                           input logic poke_busy);
    logic rdk, iok;
    logic [1:0] st;
    rdk = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    iok = (k == 3'd3) || (k == 3'd4);
    st  = (k == 3'd0) ? 2'b11 : rdk ? 2'b10 : 2'b01;
    req = 1'b1; kind = k; addr = a; wdata = wd; ad_in = ~rv;
    @(posedge clk); @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~wd;
    // T1
    chk("R2 T1 addr", {ale, ad_oe, ad_out, a_hi}, {1'b1, 1'b1, a[7:0], a[15:8]});
    chk("R3 T1 status", {io_m, s1, s0, busy}, {iok, st, 1'b1});
    chk("R4 R5 T1 strobes", {rd_n, wr_n}, 2'b11);
    @(posedge clk); @(negedge clk);
    // T2
    chk("R2 T2 ale", ale, 1'b0);
    chk("R10 T2 a_hi", a_hi, a[15:8]);
    chk("R3 T2 status", {io_m, s1, s0, busy}, {iok, st, 1'b1});
    if (rdk) chk("R4 T2 read", {rd_n, wr_n, ad_oe}, 3'b010);
    else     chk("R5 T2 write", {rd_n, wr_n, ad_oe, ad_out}, {3'b101, wd});
    if (poke_busy) begin
      req = 1'b1; kind = 3'd4; addr = 16'h7777;
    end
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    // T3
    ad_in = rv;
    chk("R10 T3 a_hi", a_hi, a[15:8]);
    chk("R3 R9 T3 status", {io_m, s1, s0, busy, ale}, {iok, st, 1'b1, 1'b0});
    if (rdk) chk("R4 T3 read", {rd_n, wr_n, ad_oe}, 3'b010);
    else     chk("R5 T3 write", {rd_n, wr_n, ad_oe, ad_out}, {3'b101, wd});
    chk("R6 no early capture", rdata, exp_rd);
    @(posedge clk); @(negedge clk);
    ad_in = 8'h5E;
    if (rdk) exp_rd = rv;
    if (k == 3'd0) begin
      chk("R7 T4 pins", {busy, rd_n, wr_n, ad_oe, ale, done}, 6'b111000);
      chk("R7 T4 status", {io_m, s1, s0, a_hi}, {3'b011, a[15:8]});
      @(posedge clk); @(negedge clk);
    end
    chk("R8 done pulse", {done, busy}, 2'b10);
    chk("R6 rdata", rdata, exp_rd);
    chk_idle("R8 end");
    @(posedge clk); @(negedge clk);
    chk("R8 done one clock", done, 1'b0);
    chk("R9 no restart", {ale, busy}, 2'b00);
    chk("R6 rdata hold", rdata, exp_rd);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 reset done/rdata", {done, rdata}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    for (int i = 0; i < 7; i++) begin
      run_cycle(VEC[i][34:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    end

    // request during a running cycle is ignored
    run_cycle(3'd1, 16'h1234, 8'h00, 8'h4D, 1'b1);
    // write after read keeps captured byte
    run_cycle(3'd4, 16'h0042, 8'h24, 8'h99, 1'b1);
    chk("R6 write keeps rdata", rdata, 8'h4D);

    // unused kind codes ignored
    for (int c = 5; c < 8; c++) begin
      req = 1'b1; kind = 3'(c); addr = 16'hABCD;
      @(posedge clk); @(negedge clk);
      req = 1'b0;
      chk("R9 bad kind no T1", {ale, busy}, 2'b00);
      chk_idle("R9 bad kind");
      @(posedge clk); @(negedge clk);
      chk("R9 bad kind no done", done, 1'b0);
    end

    // back-to-back fetch right after reset pulse
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears rdata", rdata, 8'h00);
    exp_rd = 8'h00;
    rst_n = 1'b1;
    @(negedge clk);
    run_cycle(3'd0, 16'h8000, 8'h00, 8'h01, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule